// File: doc/BRIEF.md
# Accelerator Unlock Knock Sequencer

This block guards the configuration access of a CPU speed accelerator behind a knock sequence. It watches CPU writes to a single I/O register. The external address decoder signals that register with `addr_hit`. A write counts only while the `model_en` input is set, so the same logic can sit in machine variants that have no accelerator.

A run of writes of the knock byte (0x5A) moves an internal stage count forward. Once the count reaches the configured total, the block raises `unlocked`. Two other kinds of write lock the block again, with different effects on acceleration:

- A write of the commit byte (0xA5) puts the pending settings into effect. It fires a single-cycle `apply_pulse` and turns acceleration on.
- A write of any other byte turns acceleration off.

The only setting modelled is the single acceleration enable. Both relocking writes return the stage count to zero.

Top module: `accel_knock_unlock`

## Requirements
- R1: A write is accepted only in a cycle where `wr_en`, `addr_hit` and `model_en` are all 1. In any other cycle `unlocked`, `accel_en` and the stage count keep their values, and `apply_pulse` is 0.
- R2: Each accepted write of 0x5A raises the stage count by one. With fewer than `KNOCK_COUNT` such writes since the last relock, `unlocked` stays 0. Cycles with no accepted write do not break the run.
- R3: `unlocked` becomes 1 on the clock edge that accepts the `KNOCK_COUNT`-th write of 0x5A, and it is visible in the following cycle.
- R4: Once the count reaches `KNOCK_COUNT`, it saturates there. Further accepted writes of 0x5A keep `unlocked` at 1.
- R5: An accepted write of 0xA5 has these effects after the edge:
  - `apply_pulse` is 1 for exactly that one cycle.
  - `accel_en` is 1.
  - `unlocked` is 0 and the stage count is 0.
  - These effects apply whether or not the block was unlocked.
- R6: An accepted write of any byte other than 0x5A or 0xA5 has these effects after the edge:
  - `accel_en` is 0.
  - `unlocked` is 0 and the stage count is 0.
  - `apply_pulse` stays 0.
- R7: While `rst_n` is 0, `unlocked` and `apply_pulse` are 0, `accel_en` is 1, and the stage count is 0.
- R8: After any relock, `unlocked` rises again only after a fresh run of `KNOCK_COUNT` accepted writes of 0x5A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| model_en | input | 1 | Enables the sequencer for variants that have the accelerator |
| wr_en | input | 1 | CPU write strobe |
| addr_hit | input | 1 | Decoded match of the knock register address |
| wr_data | input | 8 | Byte written by the CPU |
| unlocked | output | 1 | Configuration access is open |
| apply_pulse | output | 1 | One-cycle strobe when the pending settings are committed |
| accel_en | output | 1 | Acceleration enable, 1 out of reset |

## Verification
The bench builds the block with `KNOCK_COUNT` = 4 and the default knock and commit bytes. This makes it possible to stop one knock short of unlocking and to continue several knocks past saturation. The bench also covers:
- Writes gated off by each qualifying input in turn.
- Idle gaps placed inside a knock run.
- A commit on a locked block.
- Back-to-back commits, each of which must produce its own pulse.
- An abort followed by a fresh full run.

// File: rtl/accel_knock_unlock.sv
module accel_knock_unlock #(
  parameter int          DATA_W      = 8,
  parameter int          KNOCK_COUNT = 4,
  parameter [DATA_W-1:0] KNOCK_VAL   = 8'h5A,
  parameter [DATA_W-1:0] COMMIT_VAL  = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              model_en,
  input  logic              wr_en,
  input  logic              addr_hit,
  input  logic [DATA_W-1:0] wr_data,
  output logic              unlocked,
  output logic              apply_pulse,
  output logic              accel_en
);

  localparam int STAGE_W = $clog2(KNOCK_COUNT + 1);
  localparam logic [STAGE_W-1:0] STAGE_TOP = STAGE_W'(KNOCK_COUNT);

  logic [STAGE_W-1:0] stage;

  wire take     = wr_en & addr_hit & model_en;
  wire is_knock = take & (wr_data == KNOCK_VAL);
  wire is_commit = take & (wr_data == COMMIT_VAL);
  wire is_abort = take & ~is_knock & ~is_commit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage       <= '0;
      apply_pulse <= 1'b0;
      accel_en    <= 1'b1;
    end else begin
      apply_pulse <= is_commit;
      if (is_knock) begin
        if (stage != STAGE_TOP) stage <= stage + 1'b1;
      end else if (is_commit) begin
        stage    <= '0;
        accel_en <= 1'b1;
      end else if (is_abort) begin
        stage    <= '0;
        accel_en <= 1'b0;
      end
    end
  end

  assign unlocked = (stage == STAGE_TOP);

  // R1: an unaccepted cycle changes nothing and fires no pulse
  a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(stage) && $stable(accel_en) && !apply_pulse);

  // R3: the last knock of a run opens access
  a_r3_unlock_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (is_knock && stage == STAGE_TOP - 1'b1) |=> unlocked);

  // R4: knocking while open keeps it open
  a_r4_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (is_knock && unlocked) |=> unlocked);

  // R5: a commit relocks, pulses and enables
  a_r5_commit: assert property (@(posedge clk) disable iff (!rst_n)
    is_commit |=> !unlocked && apply_pulse && accel_en && stage == '0);

  // R5: a pulse only follows an accepted commit
  a_r5_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
    apply_pulse |-> $past(is_commit));

  // R6: an abort relocks and disables without a pulse
  a_r6_abort: assert property (@(posedge clk) disable iff (!rst_n)
    is_abort |=> !unlocked && !accel_en && !apply_pulse);

  // R2: the count never passes its top value
  a_r2_stage_bound: assert property (@(posedge clk) disable iff (!rst_n)
    stage <= STAGE_TOP);

endmodule

// File: tb/tb_accel_knock_unlock.sv
module tb_accel_knock_unlock;
  localparam int K = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic model_en = 1'b0, wr_en = 1'b0, addr_hit = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic unlocked, apply_pulse, accel_en;

  always #2 clk = ~clk;

  accel_knock_unlock #(.DATA_W(8), .KNOCK_COUNT(K), .KNOCK_VAL(8'h5A), .COMMIT_VAL(8'hA5)) dut (
    .clk(clk), .rst_n(rst_n), .model_en(model_en), .wr_en(wr_en), .addr_hit(addr_hit),
    .wr_data(wr_data), .unlocked(unlocked), .apply_pulse(apply_pulse), .accel_en(accel_en));

  int checks = 0, fails = 0;
  bit running = 1'b0;
  logic [2:0] exp_q[$];
  string      tag_q[$];

  int m_stage = 0;
  bit m_acc = 1'b1;

  task automatic chk(input logic [2:0] got, input logic [2:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: {unlocked,apply,accel} got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic step(input bit w, input bit h, input bit m, input logic [7:0] d, input string tag);
    bit ap = 1'b0;
    @(negedge clk);
    wr_en = w; addr_hit = h; model_en = m; wr_data = d;
    if (w && h && m) begin
      if (d == 8'h5A) begin
        if (m_stage < K) m_stage++;
      end else if (d == 8'hA5) begin
        m_stage = 0; m_acc = 1'b1; ap = 1'b1;
      end else begin
        m_stage = 0; m_acc = 1'b0;
      end
    end
    exp_q.push_back({m_stage == K, ap, m_acc});
    tag_q.push_back(tag);
    @(posedge clk);
  endtask

  task automatic knock(input string tag);
    step(1, 1, 1, 8'h5A, tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (running && exp_q.size() > 0)
      chk({unlocked, apply_pulse, accel_en}, exp_q.pop_front(), tag_q.pop_front());
  end

  initial begin
    #4000;
    fails++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 chk({unlocked, apply_pulse, accel_en}, 3'b001, "R7 reset values");
    @(negedge clk) rst_n = 1'b1;
    running = 1'b1;

    step(1, 1, 0, 8'h33, "R1 model disabled");
    step(1, 0, 1, 8'h33, "R1 no address hit");
    step(0, 1, 1, 8'h33, "R1 no strobe");
    for (int i = 0; i < K - 1; i++) knock("R2 partial run stays locked");
    step(0, 0, 1, 8'h00, "R2 gap inside run");
    knock("R3 last knock unlocks");
    knock("R4 saturated knock");
    knock("R4 saturated knock again");
    step(1, 0, 1, 8'h11, "R1 stray write ignored while open");
    step(1, 1, 1, 8'hA5, "R5 commit relocks with pulse");
    step(0, 0, 1, 8'h00, "R5 pulse ends");
    step(1, 1, 1, 8'h00, "R6 abort disables");
    knock("R8 fresh run after abort");
    knock("R8 fresh run after abort");
    step(1, 1, 1, 8'h5B, "R6 abort mid run");
    for (int i = 0; i < K; i++) knock("R8 full run after abort");
    step(1, 1, 1, 8'hA5, "R5 commit after unlock");
    step(1, 1, 1, 8'hA5, "R5 back-to-back commit on locked block");
    step(1, 1, 1, 8'hFF, "R6 abort");
    step(1, 1, 0, 8'hA5, "R1 commit ignored when model disabled");
    step(1, 1, 1, 8'hA5, "R5 commit re-enables");
    for (int i = 0; i < K; i++) knock("R3 unlock before reset");
    @(negedge clk) rst_n = 1'b0;
    running = 1'b0;
    @(posedge clk); #1;
    chk({unlocked, apply_pulse, accel_en}, 3'b001, "R7 reset clears unlocked");
    repeat (2) @(posedge clk);
    #1 if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: %0d items left expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule